// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block runs one external asynchronous memory access at a time for a single chip select. A host presents an address, a direction and write data on a request/acknowledge port. The block then drives the active-low chip select, read strobe and write strobe, presents the address, and drives or samples the data bus. When the access is complete it returns a one-clock acknowledge, together with the read data for reads.

Access timing comes from three compressed timing codes and a small set of mode inputs. The setup code gives the delay from chip select to strobe. The pulse code gives the strobe width. The cycle code gives the minimum chip-select width. Each code expands in multiplier steps, so a few bits reach long delays. Reads and writes use the same timing. Chip select stays asserted for the full access. Two mode inputs let a slow device stretch the strobe with a ready line and let software switch between an 8-bit and a 16-bit bus between transfers. After a read, a programmable idle gap lets the device release the data bus before the next access starts.

Top module: `extbus_cycle_gen`

## Requirements
- R1: While `rst` is high (synchronous, active high), `mem_cs_n`, `mem_rd_n` and `mem_wr_n` read 1, and `req_ack` and `mem_doe` read 0.
- R2: `cfg_setup` expands to S = 128·bit5 + bits[4:0]. The active strobe falls S clocks after `mem_cs_n` falls. S = 0 makes the strobe fall together with chip select.
- R3: `cfg_pulse` expands to P = 256·bit6 + bits[5:0]. With ready-wait off, the strobe stays low for exactly P clocks. P = 0 produces no strobe.
- R4: `cfg_cycle` expands to C = 256·bits[8:7] + bits[6:0]. Without wait stretching, `mem_cs_n` stays low for max(C, S+P, 1) clocks, and a strobe is only ever low while `mem_cs_n` is low.
- R5: A read (`req_write`=0) pulses only `mem_rd_n` and never drives the bus. A write pulses only `mem_wr_n`. Both use the same timing, and `mem_addr` holds the request address throughout the access.
- R6: `req_ack` is high for exactly one clock: the first clock in which `mem_cs_n` is high again after an access.
- R7: With `cfg_wait_en`=1, `mem_ready` passes through a two-flop synchroniser and the strobe holds while the synchronised value is 0. If `mem_ready` rises during the j-th low clock of the strobe, that strobe lasts P + j + 1 clocks and chip select is extended by j + 1 clocks.
- R8: With `cfg_wait_en`=0, `mem_ready` has no effect on strobe or cycle length.
- R9: Read data is captured on the clock edge where `mem_rd_n` rises. It is held until the next capture. With `cfg_wide`=1 all 16 bits are returned. With `cfg_wide`=0 the low byte is returned with the upper byte zero.
- R10: During a write, `mem_doe` is 1 on every clock that `mem_cs_n` is low. `mem_dout` carries `req_wdata`, or with `cfg_wide`=0 its low byte with the upper byte zero.
- R11: After a read, `mem_cs_n` stays high for F + 1 clocks (F = `cfg_float`, 0..15) before the next access can begin. After a write, one clock is enough.
- R12: All timing, mode and width inputs are taken when a request is accepted. Changing them during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_setup | input | 6 | Compressed setup code |
| cfg_pulse | input | 7 | Compressed strobe-width code |
| cfg_cycle | input | 9 | Compressed access-length code |
| cfg_float | input | 4 | Idle clocks added after a read |
| cfg_wait_en | input | 1 | Enable strobe stretching by `mem_ready` |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| req_valid | input | 1 | Request present; hold until `req_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | One-clock access-complete pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_addr | output | ADDR_W | Address to the device |
| mem_dout | output | DATA_W | Write data to the device |
| mem_doe | output | 1 | Data output enable |
| mem_din | input | DATA_W | Read data from the device |
| mem_ready | input | 1 | Device ready, asynchronous |

## Verification
The checker enforces, on every clock, the rules that hold for any access:
- the reset state;
- strobes only inside chip select, and never both strobes at once;
- a single-clock acknowledge that coincides with chip select rising;
- bus drive only during a write;
- read data that changes only on a rising read strobe.

Exact phase lengths are left to the directed scenarios, which compare them with values computed from the expanded codes. These scenarios cover the upper encoding ranges, the short-cycle clamp, the wait-stretch arithmetic through the synchroniser, the post-read gap and configuration latching.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
  localparam int SETUP_FW = 6;
  localparam int PULSE_FW = 7;
  localparam int CYCLE_FW = 9;
  localparam int FLOAT_FW = 4;
  localparam int CNT_W    = 10;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] stb_end;
    logic [CNT_W-1:0] span;
  } tm_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACCESS = 2'd1,
    PH_FLOAT  = 2'd2
  } phase_e;
endpackage

// File: rtl/extbus_tm_decode.sv
module extbus_tm_decode
  import extbus_pkg::*;
(
  input  logic [SETUP_FW-1:0] setup_code,
  input  logic [PULSE_FW-1:0] pulse_code,
  input  logic [CYCLE_FW-1:0] cycle_code,
  output tm_t                 tm
);
  logic [CNT_W-1:0] setup_dec;
  logic [CNT_W-1:0] pulse_dec;
  logic [CNT_W-1:0] cycle_dec;
  logic [CNT_W-1:0] active_dec;

  always_comb begin
    // top code bit(s) become multiplier steps, low bits stay linear
    setup_dec  = CNT_W'({setup_code[SETUP_FW-1], 2'b00, setup_code[SETUP_FW-2:0]});
    pulse_dec  = CNT_W'({pulse_code[PULSE_FW-1], 2'b00, pulse_code[PULSE_FW-2:0]});
    cycle_dec  = CNT_W'({cycle_code[CYCLE_FW-1:CYCLE_FW-2], 1'b0,
                         cycle_code[CYCLE_FW-3:0]});
    active_dec = setup_dec + pulse_dec;
    tm.setup   = setup_dec;
    tm.stb_end = active_dec;
    tm.span    = (cycle_dec > active_dec) ? cycle_dec : active_dec;
    if (tm.span == '0) tm.span = CNT_W'(1);
  end
endmodule

// File: rtl/extbus_sync.sv
module extbus_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
  import extbus_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  tm_t                 tm_in,
  input  logic [FLOAT_FW-1:0] float_in,
  input  logic                wait_in,
  input  logic                ready_s,
  output logic                accept,
  output logic                capture,
  output logic                cs_n,
  output logic                rd_n,
  output logic                wr_n,
  output logic                doe,
  output logic                ack
);
  phase_e              phase_q, phase_nx;
  logic [CNT_W-1:0]    t_q, t_nx;
  tm_t                 tm_q, tm_nx;
  logic [FLOAT_FW-1:0] flt_q, flt_nx;
  logic [FLOAT_FW-1:0] fcnt_q, fcnt_nx;
  logic                wr_q, wr_nx;
  logic                wen_q, wen_nx;
  logic                strb_q, strb_nx;
  logic                hold;
  logic                at_end;

  always_comb begin
    hold     = (phase_q == PH_ACCESS) && strb_q && wen_q && !ready_s;
    at_end   = (phase_q == PH_ACCESS) && !hold && (t_q == tm_q.span - CNT_W'(1));
    accept   = (phase_q == PH_IDLE) && req_valid;
    phase_nx = phase_q;
    t_nx     = t_q;
    tm_nx    = tm_q;
    flt_nx   = flt_q;
    fcnt_nx  = fcnt_q;
    wr_nx    = wr_q;
    wen_nx   = wen_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          phase_nx = PH_ACCESS;
          t_nx     = '0;
          tm_nx    = tm_in;
          flt_nx   = float_in;
          wr_nx    = req_write;
          wen_nx   = wait_in;
        end
      end
      PH_ACCESS: begin
        if (at_end) begin
          if (!wr_q && (flt_q != '0)) begin
            phase_nx = PH_FLOAT;
            fcnt_nx  = flt_q;
          end else begin
            phase_nx = PH_IDLE;
          end
        end else if (!hold) begin
          t_nx = t_q + CNT_W'(1);
        end
      end
      PH_FLOAT: begin
        if (fcnt_q <= FLOAT_FW'(1)) phase_nx = PH_IDLE;
        fcnt_nx = fcnt_q - FLOAT_FW'(1);
      end
      default: phase_nx = PH_IDLE;
    endcase
    strb_nx = (phase_nx == PH_ACCESS) && (t_nx >= tm_nx.setup) &&
              (t_nx < tm_nx.stb_end);
    capture = strb_q && !strb_nx && !wr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      t_q     <= '0;
      tm_q    <= '0;
      flt_q   <= '0;
      fcnt_q  <= '0;
      wr_q    <= 1'b0;
      wen_q   <= 1'b0;
      strb_q  <= 1'b0;
      cs_n    <= 1'b1;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      doe     <= 1'b0;
      ack     <= 1'b0;
    end else begin
      phase_q <= phase_nx;
      t_q     <= t_nx;
      tm_q    <= tm_nx;
      flt_q   <= flt_nx;
      fcnt_q  <= fcnt_nx;
      wr_q    <= wr_nx;
      wen_q   <= wen_nx;
      strb_q  <= strb_nx;
      cs_n    <= !(phase_nx == PH_ACCESS);
      rd_n    <= !(strb_nx && !wr_nx);
      wr_n    <= !(strb_nx && wr_nx);
      doe     <= (phase_nx == PH_ACCESS) && wr_nx;
      ack     <= at_end;
    end
  end
endmodule

// File: rtl/extbus_datapath.sv
module extbus_datapath #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              wide_in,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int HALF = DATA_W / 2;
  localparam int UPPER = DATA_W - HALF;

  logic wide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_dout  <= '0;
      rsp_rdata <= '0;
      wide_q    <= 1'b1;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        wide_q   <= wide_in;
        mem_dout <= wide_in ? req_wdata : {{UPPER{1'b0}}, req_wdata[HALF-1:0]};
      end
      if (capture) begin
        rsp_rdata <= wide_q ? mem_din : {{UPPER{1'b0}}, mem_din[HALF-1:0]};
      end
    end
  end
endmodule

// File: rtl/extbus_cycle_gen.sv
module extbus_cycle_gen
  import extbus_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SETUP_FW-1:0] cfg_setup,
  input  logic [PULSE_FW-1:0] cfg_pulse,
  input  logic [CYCLE_FW-1:0] cfg_cycle,
  input  logic [FLOAT_FW-1:0] cfg_float,
  input  logic                cfg_wait_en,
  input  logic                cfg_wide,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_ack,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                mem_cs_n,
  output logic                mem_rd_n,
  output logic                mem_wr_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dout,
  output logic                mem_doe,
  input  logic [DATA_W-1:0]   mem_din,
  input  logic                mem_ready
);
  tm_t  tm_dec;
  logic ready_s;
  logic accept;
  logic capture;

  extbus_tm_decode u_decode (
    .setup_code (cfg_setup),
    .pulse_code (cfg_pulse),
    .cycle_code (cfg_cycle),
    .tm         (tm_dec)
  );

  extbus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ready_sync (
    .clk (clk),
    .rst (rst),
    .d   (mem_ready),
    .q   (ready_s)
  );

  extbus_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .tm_in     (tm_dec),
    .float_in  (cfg_float),
    .wait_in   (cfg_wait_en),
    .ready_s   (ready_s),
    .accept    (accept),
    .capture   (capture),
    .cs_n      (mem_cs_n),
    .rd_n      (mem_rd_n),
    .wr_n      (mem_wr_n),
    .doe       (mem_doe),
    .ack       (req_ack)
  );

  extbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .wide_in   (cfg_wide),
    .capture   (capture),
    .mem_din   (mem_din),
    .mem_addr  (mem_addr),
    .mem_dout  (mem_dout),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/extbus_cycle_gen_chk.sv
module extbus_cycle_gen_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_cs_n,
  input logic              mem_rd_n,
  input logic              mem_wr_n,
  input logic              mem_doe,
  input logic              req_ack,
  input logic [DATA_W-1:0] rsp_rdata
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (mem_cs_n && mem_rd_n && mem_wr_n && !req_ack && !mem_doe)); // R1

  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    (!mem_rd_n || !mem_wr_n) |-> !mem_cs_n); // R4

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!mem_rd_n && !mem_wr_n)); // R5

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack); // R6

  AST_ACK_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_cs_n) |-> req_ack); // R6

  AST_DRIVE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    mem_doe |-> (!mem_cs_n && mem_rd_n)); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$rose(mem_rd_n) |-> $stable(rsp_rdata)); // R9
endmodule

bind extbus_cycle_gen extbus_cycle_gen_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .mem_cs_n  (mem_cs_n),
  .mem_rd_n  (mem_rd_n),
  .mem_wr_n  (mem_wr_n),
  .mem_doe   (mem_doe),
  .req_ack   (req_ack),
  .rsp_rdata (rsp_rdata)
);

// File: tb/extbus_cycle_gen_tb_top.sv
module extbus_cycle_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  cfg_setup = '0;
  logic [6:0]  cfg_pulse = '0;
  logic [8:0]  cfg_cycle = '0;
  logic [3:0]  cfg_float = '0;
  logic        cfg_wait_en = 1'b0;
  logic        cfg_wide = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ack;
  logic [15:0] rsp_rdata;
  logic        mem_cs_n, mem_rd_n, mem_wr_n, mem_doe;
  logic [11:0] mem_addr;
  logic [15:0] mem_dout;
  logic [15:0] mem_din = '0;
  logic        mem_ready = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  int wd_cnt = 0;
  int ob_gap, ob_cyc, ob_setup, ob_strb, ob_other, ob_bus_bad, ob_addr_bad;
  logic ob_ack;

  always #5 clk = ~clk;

  extbus_cycle_gen dut_i (
    .clk(clk), .rst(rst),
    .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_cycle(cfg_cycle),
    .cfg_float(cfg_float), .cfg_wait_en(cfg_wait_en), .cfg_wide(cfg_wide),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
    .mem_din(mem_din), .mem_ready(mem_ready)
  );

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", wd_cnt);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int dec_s(input logic [5:0] c);
    return 128 * int'(c[5]) + int'(c[4:0]);
  endfunction
  function automatic int dec_p(input logic [6:0] c);
    return 256 * int'(c[6]) + int'(c[5:0]);
  endfunction
  function automatic int dec_c(input logic [8:0] c);
    return 256 * int'(c[8:7]) + int'(c[6:0]);
  endfunction
  function automatic int exp_span(input int s, input int p, input int c);
    int m;
    m = (c > s + p) ? c : s + p;
    return (m == 0) ? 1 : m;
  endfunction

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [5:0] s, input logic [6:0] p, input logic [8:0] c,
                         input logic [3:0] f, input logic we, input logic wide);
    cfg_setup = s; cfg_pulse = p; cfg_cycle = c;
    cfg_float = f; cfg_wait_en = we; cfg_wide = wide;
  endtask

  // called at a negedge; returns at the first negedge with chip select high again
  task automatic run_access(input logic wr, input logic [15:0] wd, input int release_at,
                            input logic swap);
    int guard;
    logic [15:0] exp_d;
    logic stb, oth;
    exp_d = cfg_wide ? wd : {8'h00, wd[7:0]};
    req_valid = 1'b1; req_write = wr; req_wdata = wd;
    req_addr = 12'h3A5 ^ {4'h0, wd[7:0]};
    ob_gap = 0; guard = 0;
    while (mem_cs_n === 1'b1 && guard < 3000) begin
      ob_gap++; guard++; @(negedge clk);
    end
    req_valid = 1'b0;
    if (swap) begin cfg_setup = 6'd9; cfg_pulse = 7'd1; cfg_cycle = 9'd20; end
    ob_cyc = 0; ob_setup = -1; ob_strb = 0; ob_other = 0; ob_bus_bad = 0; ob_addr_bad = 0;
    while (mem_cs_n === 1'b0 && guard < 6000) begin
      ob_cyc++;
      stb = wr ? ~mem_wr_n : ~mem_rd_n;
      oth = wr ? ~mem_rd_n : ~mem_wr_n;
      if (oth) ob_other++;
      if (wr ? (mem_doe !== 1'b1 || mem_dout !== exp_d) : (mem_doe !== 1'b0)) ob_bus_bad++;
      if (mem_addr !== req_addr) ob_addr_bad++;
      if (stb) begin
        if (ob_setup < 0) ob_setup = ob_cyc - 1;
        ob_strb++;
        if (ob_strb == release_at) mem_ready = 1'b1;
      end else if (ob_strb > 0) begin
        mem_din = ~mem_din;
      end
      guard++;
      @(negedge clk);
    end
    ob_ack = req_ack;
  endtask

  task automatic t_reset();
    chk("R1", "cs_n in reset", int'(mem_cs_n), 1);
    chk("R1", "rd_n in reset", int'(mem_rd_n), 1);
    chk("R1", "wr_n in reset", int'(mem_wr_n), 1);
    chk("R1", "ack in reset", int'(req_ack), 0);
    chk("R1", "doe in reset", int'(mem_doe), 0);
  endtask

  task automatic t_basic_read();
    set_cfg(6'd2, 7'd3, 9'd8, 4'd0, 1'b0, 1'b1);
    mem_din = 16'hA5C3;
    run_access(1'b0, 16'h0011, -1, 1'b0);
    chk("R2", "read setup", ob_setup, 2);
    chk("R3", "read strobe", ob_strb, 3);
    chk("R4", "read cs width", ob_cyc, exp_span(2, 3, 8));
    chk("R5", "write strobe during read", ob_other, 0);
    chk("R5", "bus driven during read", ob_bus_bad, 0);
    chk("R5", "address hold", ob_addr_bad, 0);
    chk("R9", "wide read data", int'(rsp_rdata), 16'hA5C3);
    chk("R6", "ack at cs rise", int'(ob_ack), 1);
    @(negedge clk);
    chk("R6", "ack one clock", int'(req_ack), 0);
  endtask

  task automatic t_basic_write();
    set_cfg(6'd2, 7'd3, 9'd8, 4'd0, 1'b0, 1'b1);
    run_access(1'b1, 16'h1234, -1, 1'b0);
    chk("R2", "write setup", ob_setup, 2);
    chk("R3", "write strobe", ob_strb, 3);
    chk("R4", "write cs width", ob_cyc, 8);
    chk("R5", "read strobe during write", ob_other, 0);
    chk("R10", "write drive/data", ob_bus_bad, 0);
    @(negedge clk);
  endtask

  task automatic t_narrow();
    set_cfg(6'd1, 7'd2, 9'd4, 4'd0, 1'b0, 1'b0);
    mem_din = 16'hBEEF;
    run_access(1'b0, 16'h0022, -1, 1'b0);
    chk("R9", "narrow read data", int'(rsp_rdata), 16'h00EF);
    run_access(1'b1, 16'hCAFE, -1, 1'b0);
    chk("R10", "narrow write data", ob_bus_bad, 0);
    @(negedge clk);
  endtask

  task automatic t_short_cycle();
    set_cfg(6'd3, 7'd4, 9'd2, 4'd0, 1'b0, 1'b1);
    run_access(1'b1, 16'h0101, -1, 1'b0);
    chk("R4", "cycle clamped to setup+pulse", ob_cyc, 7);
    set_cfg(6'd0, 7'd0, 9'd0, 4'd0, 1'b0, 1'b1);
    run_access(1'b1, 16'h0202, -1, 1'b0);
    chk("R4", "all-zero cycle width", ob_cyc, 1);
    chk("R3", "zero pulse no strobe", ob_strb, 0);
    set_cfg(6'd0, 7'd2, 9'd5, 4'd0, 1'b0, 1'b1);
    run_access(1'b0, 16'h0303, -1, 1'b0);
    chk("R2", "zero setup", ob_setup, 0);
    chk("R4", "cycle width 5", ob_cyc, 5);
    @(negedge clk);
  endtask

  task automatic t_encoding();
    logic [5:0] s; logic [6:0] p; logic [8:0] c;
    s = 6'b100001; p = 7'b1000010; c = 9'b100000101;
    set_cfg(s, p, c, 4'd0, 1'b0, 1'b1);
    run_access(1'b1, 16'h0404, -1, 1'b0);
    chk("R2", "upper setup range", ob_setup, dec_s(s));
    chk("R3", "upper pulse range", ob_strb, dec_p(p));
    chk("R4", "third cycle window", ob_cyc, exp_span(dec_s(s), dec_p(p), dec_c(c)));
    s = 6'd5; p = 7'd1; c = 9'b111111111;
    set_cfg(s, p, c, 4'd0, 1'b0, 1'b1);
    run_access(1'b1, 16'h0505, -1, 1'b0);
    chk("R4", "top cycle window", ob_cyc, exp_span(dec_s(s), dec_p(p), dec_c(c)));
    s = 6'd0; p = 7'b1111111; c = 9'd0;
    set_cfg(s, p, c, 4'd0, 1'b0, 1'b1);
    run_access(1'b1, 16'h0606, -1, 1'b0);
    chk("R3", "largest pulse", ob_strb, dec_p(p));
    @(negedge clk);
  endtask

  task automatic t_wait();
    set_cfg(6'd1, 7'd3, 9'd4, 4'd0, 1'b1, 1'b1);
    mem_ready = 1'b0;
    repeat (4) @(negedge clk);
    run_access(1'b0, 16'h0707, 4, 1'b0);
    chk("R7", "stretched strobe", ob_strb, 3 + 4 + 1);
    chk("R7", "stretched cs", ob_cyc, 4 + 4 + 1);
    @(negedge clk);
  endtask

  task automatic t_wait_off();
    set_cfg(6'd1, 7'd3, 9'd4, 4'd0, 1'b0, 1'b1);
    mem_ready = 1'b0;
    repeat (4) @(negedge clk);
    run_access(1'b0, 16'h0808, -1, 1'b0);
    chk("R8", "ready ignored strobe", ob_strb, 3);
    chk("R8", "ready ignored cs", ob_cyc, 4);
    mem_ready = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_float();
    set_cfg(6'd1, 7'd2, 9'd3, 4'd5, 1'b0, 1'b1);
    run_access(1'b0, 16'h0909, -1, 1'b0);
    run_access(1'b1, 16'h0A0A, -1, 1'b0);
    chk("R11", "gap after read F=5", ob_gap, 6);
    run_access(1'b1, 16'h0B0B, -1, 1'b0);
    chk("R11", "gap after write", ob_gap, 1);
    cfg_float = 4'd15;
    run_access(1'b0, 16'h0C0C, -1, 1'b0);
    run_access(1'b0, 16'h0D0D, -1, 1'b0);
    chk("R11", "gap after read F=15", ob_gap, 16);
    cfg_float = 4'd0;
    run_access(1'b0, 16'h0E0E, -1, 1'b0);
    run_access(1'b0, 16'h0F0F, -1, 1'b0);
    chk("R11", "gap after read F=0", ob_gap, 1);
    @(negedge clk);
  endtask

  task automatic t_latch();
    set_cfg(6'd2, 7'd3, 9'd8, 4'd0, 1'b0, 1'b1);
    run_access(1'b0, 16'h1010, -1, 1'b1);
    chk("R12", "setup kept", ob_setup, 2);
    chk("R12", "strobe kept", ob_strb, 3);
    chk("R12", "cycle kept", ob_cyc, 8);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_basic_read();
    t_basic_write();
    t_narrow();
    t_short_cycle();
    t_encoding();
    t_wait();
    t_wait_off();
    t_float();
    t_latch();
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule